// File: doc/BRIEF.md
# Equivalent-Time Sample Interleaving Buffer

This block rebuilds one period of a repetitive pulse at a fine equivalent sample rate from a slow two-channel converter stream. The sample clock runs at a fractional ratio of the pulse repetition rate. Consecutive samples therefore land at different offsets inside the pulse. One acquisition spans K repetition periods and collects NS samples per channel, and together these fill one period on an NS-point grid. With the default values, an 80 MHz sample clock and a 7.875 MHz repetition rate, K is 63 and NS is 640. The rebuilt period then has an equivalent rate of 5.04 GS/s.

A start pulse marks a repetition-period boundary. From that pulse on, each I/Q pair is stored in the slot that matches its time offset, so sample n goes to slot (n·K) mod NS. The slot is stepped by adding K and wrapping, and no multiplier is used. When the last sample has been stored, a done flag rises and the buffer plays the rebuilt period out in slot order on a valid/ready stream, with a last marker on the final slot. The block assumes that the carrier phase is the same at every pulse start and does not correct for phase.

Top module: `ets_interleaver`

## Requirements
- R1: While reset is high at a clock edge, done and out_valid are low after that edge, and the block is idle.
- R2: A start that is high in the idle state begins an acquisition, and the sample presented in that same cycle is sample 0. A start during capture or readout has no effect.
- R3: Sample n of an acquisition (n = 0..NS-1) is stored in slot (n·K) mod NS. The defaults are K = 63 and NS = 640.
- R4: In one acquisition, every slot is written exactly once, because K and NS are coprime. A full readout therefore returns NS distinct captured samples.
- R5: done rises in the cycle after the NS-th sample is stored. Capture then stops, and later input samples do not change the stored period.
- R6: During readout, out_valid is high and slots are presented in ascending order from 0. The pointer advances only on a beat where out_ready is high. While out_ready is low, the outputs hold steady.
- R7: out_last is high only while slot NS-1 is presented. After that beat is accepted, done and out_valid are low in the next cycle and the block is idle.
- R8: The Q channel is placed into slots by the same addressing as the I channel, so out_i and out_q always come from the same sample.
- R9: A synchronous reset during capture or readout returns the block to idle with done low. The next start begins a fresh acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse aligned to a repetition-period boundary that begins an acquisition |
| in_i | input | DW | In-phase sample |
| in_q | input | DW | Quadrature sample |
| done | output | 1 | The acquisition is complete and the rebuilt period is being read out |
| out_valid | output | 1 | out_i, out_q and out_last carry a slot |
| out_ready | input | 1 | The consumer accepts the current slot |
| out_i | output | DW | In-phase value of the current slot |
| out_q | output | DW | Quadrature value of the current slot |
| out_last | output | 1 | The current slot is slot NS-1 |

## Verification
The bench builds the block with its default values, DW = 12, K = 63 and NS = 640, so the full 640-slot wrap sequence and the return of the slot stepper to zero are exercised exactly as deployed. One acquisition takes about 640 cycles to capture and up to twice that to read out. This makes it possible to run several full acquisitions, to stall readout at pseudo-random beats and to reset in the middle of both capture and readout within one short run. Because the input is a ramp with a distinct value per sample, each rebuilt slot identifies the sample index that landed there.

// File: rtl/ets_interleaver.sv
module ets_interleaver #(
  parameter int DW = 12,
  parameter int NS = 640,
  parameter int K  = 63
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] in_i,
  input  logic [DW-1:0] in_q,
  output logic          done,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_i,
  output logic [DW-1:0] out_q,
  output logic          out_last
);
  localparam int AW = $clog2(NS);
  localparam logic [AW:0]   STEP = (AW+1)'(K);
  localparam logic [AW:0]   LIM  = (AW+1)'(NS);
  localparam logic [AW-1:0] TOP  = AW'(NS - 1);

  typedef enum logic [1:0] {IDLE = 2'd0, CAP = 2'd1, RD = 2'd2} st_t;

  st_t           st;
  logic [AW-1:0] slot, cnt, rd_ptr, nxt_slot;
  logic [AW:0]   sum;
  logic          wr_en, beat;
  logic [2*DW-1:0] mem [NS];

  assign sum      = {1'b0, slot} + STEP;
  assign nxt_slot = (sum >= LIM) ? AW'(sum - LIM) : sum[AW-1:0];
  assign wr_en    = (st == CAP) || (st == IDLE && start);
  assign beat     = (st == RD) && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= IDLE;
      slot   <= '0;
      cnt    <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) slot <= nxt_slot;
      case (st)
        IDLE: if (start) begin
          st  <= CAP;
          cnt <= AW'(1);
        end
        CAP: if (cnt == TOP) begin
          st     <= RD;
          cnt    <= '0;
          rd_ptr <= '0;
        end else begin
          cnt <= cnt + AW'(1);
        end
        RD: if (beat) begin
          if (rd_ptr == TOP) st <= IDLE;
          else rd_ptr <= rd_ptr + AW'(1);
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (wr_en && !rst) mem[slot] <= {in_i, in_q};

  assign {out_i, out_q} = mem[rd_ptr];
  assign out_valid      = (st == RD);
  assign done           = (st == RD);
  assign out_last       = out_valid && (rd_ptr == TOP);
endmodule

module ets_interleaver_chk #(
  parameter int DW = 12,
  parameter int NS = 640
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   start,
  input logic                   done,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic                   out_last,
  input logic [DW-1:0]          out_i,
  input logic [DW-1:0]          out_q,
  input logic [1:0]             st,
  input logic [$clog2(NS)-1:0]  slot
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!done && !out_valid)); // R1
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (done && start && !out_last) |=> done); // R2
  AST_SLOT_HOME: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd0) |-> (slot == '0)); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q) && $stable(out_last))); // R6
  AST_LAST_IN_BEAT: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid); // R7
  AST_END_IDLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> (!done && !out_valid)); // R7
endmodule

bind ets_interleaver ets_interleaver_chk #(.DW(DW), .NS(NS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done), .out_valid(out_valid),
  .out_ready(out_ready), .out_last(out_last), .out_i(out_i), .out_q(out_q),
  .st(st), .slot(slot)
);

// File: tb/sim_ets_interleaver.sv
`timescale 1ns/1ps
module sim_ets_interleaver;
  localparam int DW = 12;
  localparam int NS = 640;
  localparam int K  = 63;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, start = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_i = '0, in_q = '0;
  logic done, out_valid, out_last;
  logic [DW-1:0] out_i, out_q;

  ets_interleaver #(.DW(DW), .NS(NS), .K(K)) u0 (
    .clk(clk), .rst(rst), .start(start), .in_i(in_i), .in_q(in_q),
    .done(done), .out_valid(out_valid), .out_ready(out_ready),
    .out_i(out_i), .out_q(out_q), .out_last(out_last)
  );

  int checks = 0, errors = 0, cycles = 0, tick = 0, rdy_mode = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  int ph = 0, mn = 0, mrd = 0;
  logic [DW-1:0] mi [NS];
  logic [DW-1:0] mq [NS];
  int seen [int];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // drive inputs just after the rising edge
  always @(posedge clk) begin
    #1;
    tick++;
    lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    in_i <= DW'(tick * 3 + 5);
    in_q <= DW'(tick * 11 + 100);
    out_ready <= (rdy_mode == 0) ? 1'b1 : lfsr[0];
  end

  // behavioural reference model
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      ph = 0; mn = 0; mrd = 0;
      seen.delete();
    end else begin
      case (ph)
        0: if (start) begin
          mi[0] = in_i; mq[0] = in_q; mn = 1; ph = 1;
        end
        1: begin
          mi[(mn * K) % NS] = in_i;
          mq[(mn * K) % NS] = in_q;
          mn++;
          if (mn == NS) begin ph = 2; mrd = 0; end
        end
        default: if (out_ready) begin
          if (mrd == NS - 1) ph = 0;
          else mrd++;
        end
      endcase
    end
    if (cycles > 150000 && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    if (!finished && !rst) begin
      check(done == (ph == 2), "R5 done", done, ph == 2);
      check(out_valid == (ph == 2), "R6 valid", out_valid, ph == 2);
      check(out_last == (ph == 2 && mrd == NS - 1), "R7 last", out_last, ph == 2 && mrd == NS - 1);
      if (ph == 2) begin
        check(out_i == mi[mrd], "R3 slot I", out_i, mi[mrd]);
        check(out_q == mq[mrd], "R8 slot Q", out_q, mq[mrd]);
        if (out_valid && out_ready) begin
          if (seen.exists(int'(out_i))) seen[int'(out_i)]++;
          else seen[int'(out_i)] = 1;
          if (mrd == NS - 1) begin
            int dup = 0;
            foreach (seen[v]) if (seen[v] != 1) dup++;
            check(seen.num() == NS && dup == 0, "R4 distinct slots", seen.num(), NS);
            seen.delete();
          end
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_start();
    start = 1'b1; cyc(1); start = 1'b0;
  endtask

  task automatic wait_done(input bit level);
    while (done != level) cyc(1);
  endtask

  initial begin
    cyc(5);
    @(negedge clk);
    check(!done && !out_valid, "R1 reset state", {done, out_valid}, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    cyc(3);

    // acquisition 1: start ignored during capture, always ready
    rdy_mode = 0;
    pulse_start();
    cyc(100);
    pulse_start();
    wait_done(1);
    wait_done(0);

    // acquisition 2: stalled readout, start ignored during readout
    cyc(4);
    rdy_mode = 1;
    pulse_start();
    wait_done(1);
    cyc(50);
    pulse_start();
    @(negedge clk);
    check(done == 1'b1, "R2 start in readout", done, 1);
    @(posedge clk); #1;
    wait_done(0);

    // reset mid capture
    cyc(2);
    pulse_start();
    cyc(200);
    rst = 1'b1; cyc(2); rst = 1'b0;
    @(negedge clk);
    check(!done && !out_valid, "R9 reset in capture", {done, out_valid}, 0);
    @(posedge clk); #1;

    // full acquisition, then reset mid readout
    pulse_start();
    wait_done(1);
    cyc(30);
    rst = 1'b1; cyc(1); rst = 1'b0;
    @(negedge clk);
    check(!done && !out_valid, "R9 reset in readout", {done, out_valid}, 0);
    @(posedge clk); #1;

    // final acquisition, always ready
    rdy_mode = 0;
    pulse_start();
    wait_done(1);
    wait_done(0);
    cyc(5);
    finish_run();
  end
endmodule